// File: doc/BRIEF.md
# Row-Column Decoded Read-Only Memory

This block is a read-only memory whose stored words are fixed by a module parameter. The address is cut into two equal halves. The upper half drives a row decoder, and the lower half drives a column decoder. Each decoder produces its own set of one-hot select lines. Neither decoder works out which single word is meant. That choice is made inside the storage array: each cell ANDs its own row line with its own column line. As a result only 2·2^(n/2) select lines run from the decoders into the array, compared with 2^n lines for a flat decoder.

The read enable goes to the row decoder only. When the enable is low, no row is selected, so no cell contributes and the output is all zeros. The read path is combinational by default. A parameter can add an output register, which gives one clock of read latency.

Top module: `rcrom_top`

## Requirements
- R1: With REG_OUT = 0 and rd_en high, rd_data equals the stored word for the current addr in the same cycle.
- R2: Word i is held at bits [i·DATA_W +: DATA_W] of CONTENTS. The upper ADDR_W/2 address bits choose row t and the lower ADDR_W/2 bits choose column s. The cell at (t, s) returns word t·2^(ADDR_W/2) + s.
- R3: When rd_en is low, rd_data is all zeros, for every addr value. With REG_OUT = 1 this takes effect one clock later.
- R4: The enable gates the row decoder only. The column decoder drives exactly one column line at all times, and no row line is active while rd_en is low.
- R5: While rd_en is high, exactly one row line is active, so rd_data is one single word and never the OR of several words.
- R6: With REG_OUT = 1, rd_data shows the result of the addr and rd_en values sampled at the previous rising clk edge.
- R7: With REG_OUT = 1, rd_data is all zeros while rst_n is low, which is an asynchronous active-low reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| rd_en | input | 1 | Read enable, applied to the row decoder |
| addr | input | ADDR_W | Word address, with the upper half as row and the lower half as column |
| rd_data | output | DATA_W | Selected word, or zero when not enabled |

## Verification
The bench builds two copies of the block:
- A 4-bit-address, 8-bit-data copy with a combinational read. It sweeps a 4×4 array and exercises same-cycle reads and enable gating.
- A 6-bit-address, 12-bit-data copy with the output register. It sweeps an 8×8 array with one cycle of latency and checks the reset value.

Both copies are filled with distinct words in which a wrong mapping or an OR of two cells shows up. Reading every address catches a row/column swap or a mistake at a half boundary.

// File: rtl/rcrom_pkg.sv
package rcrom_pkg;

   // Number of select lines on one side of the square array.
   function automatic int unsigned side_lines(input int unsigned addr_w);
      return 1 << (addr_w / 2);
   endfunction

   // Legal address width: even and at least two bits.
   function automatic bit addr_w_ok(input int unsigned addr_w);
      return (addr_w >= 2) && ((addr_w % 2) == 0);
   endfunction

endpackage

// File: rtl/rcrom_half_dec.sv
module rcrom_half_dec #(
   parameter int unsigned SEL_W = 2,
   localparam int unsigned LINES = 1 << SEL_W
) (
   input  logic             en,
   input  logic [SEL_W-1:0] sel,
   output logic [LINES-1:0] lines
);

   always_comb begin
      lines = '0;
      if (en) lines[sel] = 1'b1;
   end

endmodule

// File: rtl/rcrom_cell_array.sv
module rcrom_cell_array #(
   parameter int unsigned SIDE   = 4,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned DEPTH = SIDE * SIDE,
   parameter logic [DEPTH*DATA_W-1:0] CONTENTS = '0
) (
   input  logic [SIDE-1:0]   row_sel,
   input  logic [SIDE-1:0]   col_sel,
   output logic [DATA_W-1:0] word_out
);

   logic [DATA_W-1:0] cell_word [DEPTH];

   // Each cell forms its own row AND column pick and gates its word.
   for (genvar t = 0; t < SIDE; t++) begin : g_row
      for (genvar s = 0; s < SIDE; s++) begin : g_col
         localparam int unsigned IDX = t * SIDE + s;
         logic pick;
         assign pick = row_sel[t] & col_sel[s];
         assign cell_word[IDX] = {DATA_W{pick}} & CONTENTS[IDX*DATA_W +: DATA_W];
      end
   end

   always_comb begin
      word_out = '0;
      for (int i = 0; i < DEPTH; i++) word_out |= cell_word[i];
   end

endmodule

// File: rtl/rcrom_out_stage.sv
module rcrom_out_stage #(
   parameter int unsigned DATA_W  = 8,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= d;
      end
   end else begin : g_pass
      assign q = d;
   end

endmodule

// File: rtl/rcrom_top.sv
module rcrom_top #(
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned DATA_W  = 8,
   parameter bit          REG_OUT = 1'b0,
   localparam int unsigned DEPTH  = 1 << ADDR_W,
   parameter logic [DEPTH*DATA_W-1:0] CONTENTS = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] rd_data
);
   import rcrom_pkg::*;

   localparam int unsigned HALF = ADDR_W / 2;
   localparam int unsigned SIDE = side_lines(ADDR_W);

   if (!addr_w_ok(ADDR_W)) begin : g_bad_addr_w
      $error("rcrom_top: ADDR_W must be even and at least 2");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("rcrom_top: DATA_W must be at least 1");
   end

   logic [SIDE-1:0]   row_sel;
   logic [SIDE-1:0]   col_sel;
   logic [DATA_W-1:0] array_word;

   rcrom_half_dec #(.SEL_W(HALF)) u_row_dec (
      .en    (rd_en),
      .sel   (addr[ADDR_W-1:HALF]),
      .lines (row_sel)
   );

   rcrom_half_dec #(.SEL_W(HALF)) u_col_dec (
      .en    (1'b1),
      .sel   (addr[HALF-1:0]),
      .lines (col_sel)
   );

   rcrom_cell_array #(
      .SIDE     (SIDE),
      .DATA_W   (DATA_W),
      .CONTENTS (CONTENTS)
   ) u_array (
      .row_sel  (row_sel),
      .col_sel  (col_sel),
      .word_out (array_word)
   );

   rcrom_out_stage #(
      .DATA_W  (DATA_W),
      .REG_OUT (REG_OUT)
   ) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (array_word),
      .q     (rd_data)
   );

endmodule

// File: rtl/rcrom_chk.sv
module rcrom_chk #(
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned DATA_W  = 8,
   parameter bit          REG_OUT = 1'b0,
   localparam int unsigned HALF   = ADDR_W / 2,
   localparam int unsigned SIDE   = 1 << HALF
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] rd_data,
   input logic [SIDE-1:0]   row_sel,
   input logic [SIDE-1:0]   col_sel
);

   // R4: the column side never depends on the enable
   p_col_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(col_sel) == 1);

   // R4: no row line while disabled
   p_row_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> (row_sel == '0));

   // R5: exactly one row while enabled
   p_row_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> ($countones(row_sel) == 1));

   // R2: upper half picks the row, lower half the column
   p_row_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> row_sel[addr[ADDR_W-1:HALF]]);

   p_col_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
      col_sel[addr[HALF-1:0]]);

   if (REG_OUT) begin : g_reg_chk
      // R3: disabled read gives zero one clock later
      p_zero_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_en |=> (rd_data == '0));
   end else begin : g_comb_chk
      // R3: disabled read gives zero at once
      p_zero_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_en |-> (rd_data == '0));
   end

endmodule

bind rcrom_top rcrom_chk #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .REG_OUT (REG_OUT)
) u_rcrom_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .rd_en   (rd_en),
   .addr    (addr),
   .rd_data (rd_data),
   .row_sel (row_sel),
   .col_sel (col_sel)
);

// File: tb/test_rcrom_top.sv
module test_rcrom_top;

   localparam int unsigned AW_C = 4;
   localparam int unsigned DW_C = 8;
   localparam int unsigned AW_R = 6;
   localparam int unsigned DW_R = 12;

   // Distinct, scrambled words: a wrong cell or an OR of two cells differs.
   function automatic logic [31:0] wgen(input int a, input int salt);
      return ((a * 181 + salt * 97 + 3) ^ (a << 5) ^ (a << 9)) & 32'hFFFF_FFFF;
   endfunction

   function automatic logic [DW_C-1:0] exp_c(input int a);
      logic [31:0] w;
      w = wgen(a, 1);
      return w[DW_C-1:0];
   endfunction

   function automatic logic [DW_R-1:0] exp_r(input int a);
      logic [31:0] w;
      w = wgen(a, 2);
      return w[DW_R-1:0];
   endfunction

   function automatic logic [(1<<AW_C)*DW_C-1:0] fill_c();
      logic [(1<<AW_C)*DW_C-1:0] v;
      v = '0;
      for (int i = 0; i < (1 << AW_C); i++) v[i*DW_C +: DW_C] = exp_c(i);
      return v;
   endfunction

   function automatic logic [(1<<AW_R)*DW_R-1:0] fill_r();
      logic [(1<<AW_R)*DW_R-1:0] v;
      v = '0;
      for (int i = 0; i < (1 << AW_R); i++) v[i*DW_R +: DW_R] = exp_r(i);
      return v;
   endfunction

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            en_c = 1'b0;
   logic [AW_C-1:0] addr_c = '0;
   logic [DW_C-1:0] data_c;
   logic            en_r = 1'b0;
   logic [AW_R-1:0] addr_r = '0;
   logic [DW_R-1:0] data_r;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   rcrom_top #(
      .ADDR_W (AW_C), .DATA_W (DW_C), .REG_OUT (1'b0), .CONTENTS (fill_c())
   ) i_rcrom_top (
      .clk (clk), .rst_n (rst_n), .rd_en (en_c), .addr (addr_c), .rd_data (data_c)
   );

   rcrom_top #(
      .ADDR_W (AW_R), .DATA_W (DW_R), .REG_OUT (1'b1), .CONTENTS (fill_r())
   ) i_rcrom_top_reg (
      .clk (clk), .rst_n (rst_n), .rd_en (en_r), .addr (addr_r), .rd_data (data_r)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // R7, R3: reset state
   task automatic t_reset_state();
      @(negedge clk);
      en_r = 1'b1; addr_r = 6'd5; en_c = 1'b0; addr_c = 4'd7;
      @(posedge clk); #1;
      check("R7 reg out zero in reset", 32'(data_r), 32'h0);
      check("R3 comb out zero when disabled", 32'(data_c), 32'h0);
      @(negedge clk); rst_n = 1'b1; en_r = 1'b0;
   endtask

   // R1, R2, R5: every address, combinational copy
   task automatic t_sweep_comb();
      for (int a = 0; a < (1 << AW_C); a++) begin
         @(negedge clk); en_c = 1'b1; addr_c = AW_C'(a);
         #1;
         check("R1 R2 R5 comb read", 32'(data_c), 32'(exp_c(a)));
      end
   endtask

   // R3, R4: disabled for all column/row values
   task automatic t_disabled_comb();
      for (int a = 0; a < (1 << AW_C); a += 3) begin
         @(negedge clk); en_c = 1'b0; addr_c = AW_C'(a);
         #1;
         check("R3 R4 disabled comb", 32'(data_c), 32'h0);
      end
   endtask

   // R2: corners and row boundaries, row and column distinct
   task automatic t_corners_comb();
      int pts [6] = '{0, 3, 4, 12, 15, 9};
      for (int i = 0; i < 6; i++) begin
         @(negedge clk); en_c = 1'b1; addr_c = AW_C'(pts[i]);
         #1;
         check("R2 corner", 32'(data_c), 32'(exp_c(pts[i])));
      end
   endtask

   // R6, R2, R5: registered copy, one clock latency
   task automatic t_sweep_reg();
      for (int a = 0; a < (1 << AW_R); a++) begin
         @(negedge clk); en_r = 1'b1; addr_r = AW_R'(a);
         #1;
         if (a > 0) check("R6 latency before edge", 32'(data_r), 32'(exp_r(a - 1)));
         @(posedge clk); #1;
         check("R6 R2 R5 reg read", 32'(data_r), 32'(exp_r(a)));
      end
   endtask

   // R3: registered copy disabled
   task automatic t_disabled_reg();
      @(negedge clk); en_r = 1'b1; addr_r = 6'd42;
      @(posedge clk); #1;
      check("R6 before disable", 32'(data_r), 32'(exp_r(42)));
      @(negedge clk); en_r = 1'b0; addr_r = 6'd17;
      #1;
      check("R3 reg holds until edge", 32'(data_r), 32'(exp_r(42)));
      @(posedge clk); #1;
      check("R3 reg disabled zero", 32'(data_r), 32'h0);
   endtask

   initial begin
      repeat (2) @(posedge clk);
      t_reset_state();
      t_sweep_comb();
      t_disabled_comb();
      t_corners_comb();
      t_sweep_reg();
      t_disabled_reg();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule